// File: doc/BRIEF.md
# GPU Last-Level Cache Line State Controller

This block tracks the coherence state of one line in a GPU last-level cache. It accepts core requests, memory responses and invalidating probes, and turns them into a new line state plus commands. Requests are block reads, masked writes and atomics, and any of them may carry a bypass flag that asks for the request to skip the cache. The commands go to the data array, to memory and back to the core. A static mode input chooses write-through or write-back operation. Tag lookup, replacement choice, the data array and the network are outside the block. The tag side reports whether the line is present or can be allocated, and the controller asks the data side to invalidate, allocate, merge or fill it.

Only one event is taken in a cycle. The line-side operations come out one cycle after the event. Commands to memory and replies to the core come out after a fixed request latency and a fixed response latency. Requests that cannot proceed are handed to an external park buffer, and a wake pulse releases that buffer when the busy state resolves. An event that has no meaning in the current state raises an error pulse and leaves everything unchanged.

Top module: `l2_line_ctrl`

## Requirements
- R1: After reset the state is I and every command, line-operation and error output is zero. State codes on `state_o` are I=0, V=1, M=2, W=3, IV=4, WI=5, A=6. Line-op bits are 0 invalidate, 1 allocate, 2 merge bytes, 3 fill write, 4 probe ack, 5 unblock directory, 6 park request, 7 wake waiters. Memory-command bits are 0 forward read, 1 write through, 2 write back, 3 forward atomic. Core-reply bits are 0 data, 1 write ack.
- R2: A response is taken before a probe, and a probe before a request. Only the taken event has any effect, and exactly one take output is high when any event is valid. Untaken inputs are ignored and must be presented again.
- R3: Request kind 0 is read, 1 is write and 2 is atomic. A write with the bypass flag decodes to write-evict when the line is present or allocatable, else to plain write-through. Without the flag, write-back mode decodes it to dirty write when present or allocatable, else to replacement. Write-through mode always decodes it to plain write-through.
- R4: A read hits with a data reply in V or M. In W it writes back, parks the request and goes to WI. In I it forwards the read and goes to IV, and in IV it forwards again without changing state. In WI or A it parks.
- R5: A bypass read forwards the read and ends in I. In V it also invalidates, and in M or W it also writes back and invalidates. In IV, WI or A it parks.
- R6: Plain write-through forwards the write in I and V, and also merges bytes in V. The state is unchanged. Write-evict forwards and stays in I, and in V it forwards and invalidates into I. In M or W, write-evict merges, writes back and invalidates into I. Busy states park both kinds.
- R7: A dirty write in I allocates, merges and acks into W. In V or M it merges and acks into M, and in W it merges and acks while staying in W. Busy states park.
- R8: An atomic in I or V invalidates, forwards the atomic and goes to A. In M or W it writes back, parks and goes to WI. Busy states park.
- R9: A replacement always invalidates and parks. From M or W it also writes back and goes to WI. I and V go to I, and busy states keep their state.
- R10: A probe is always acked without data. V invalidates into I, I stays in I, M goes to W, and every other state is unchanged.
- R11: A fill in IV allocates, writes the line, replies with data, unblocks the directory, wakes waiters and goes to V. Atomic data in A replies with data, wakes waiters and goes to I. A write-back ack in WI wakes waiters and goes to I. In I, V, IV or A a write-back ack is relayed to the core as a write ack.
- R12: While a bypass read is outstanding, its data response replies to the core, unblocks the directory and wakes waiters. It neither allocates nor fills, and the state is unchanged.
- R13: For an event presented in cycle c, line operations appear in cycle c+1, memory commands in cycle c+REQ_LAT (default 50) and core replies in cycle c+RSP_LAT (default 20). Each is a single-cycle pulse.
- R14: Certain events are undefined: plain write-through in M or W, a non-bypass data response in I, V, M, W or WI, a write-back ack in M or W, and request kind 3. Each of these pulses `err_o`, leaves the state unchanged and issues no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode_i | input | 1 | Static mode: 1 write-back, 0 write-through |
| req_valid_i | input | 1 | Core request present |
| req_kind_i | input | 2 | Request kind (R3) |
| req_slc_i | input | 1 | Bypass flag of the request |
| req_avail_i | input | 1 | Line present or allocatable (from tag side) |
| rsp_valid_i | input | 1 | Memory response present |
| rsp_kind_i | input | 1 | 0 data, 1 write-back ack |
| prb_valid_i | input | 1 | Invalidating probe present |
| req_take_o | output | 1 | Request taken this cycle |
| rsp_take_o | output | 1 | Response taken this cycle |
| prb_take_o | output | 1 | Probe taken this cycle |
| state_o | output | 3 | Current line state |
| line_op_o | output | 8 | Line-side operation pulses |
| mem_cmd_o | output | 4 | Delayed memory command pulses |
| core_rsp_o | output | 2 | Delayed core reply pulses |
| err_o | output | 1 | Undefined-event pulse |

## Verification
The bench drives each of the seven states through every decoded event and compares the result with an arithmetic model of the transition rules. The most telling corners are the two dirty states under a probe and under a bypass read. If M and W were swapped on a probe, the line would never leave M. A bypass read that skipped the write-back would silently drop dirty bytes. The bench also follows a bypass read with its data response; a design that forgot the pending bypass would allocate and fill the line or flag an error. Simultaneous response, probe and request show whether a lower-priority event leaks through. Each memory command and core reply must land in exactly its latency cycle and nowhere else in the window.

// File: rtl/l2ls_pkg.sv
package l2ls_pkg;

    typedef enum logic [2:0] {
        LS_I  = 3'd0,
        LS_V  = 3'd1,
        LS_M  = 3'd2,
        LS_W  = 3'd3,
        LS_IV = 3'd4,
        LS_WI = 3'd5,
        LS_A  = 3'd6
    } line_state_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_READ,
        EV_READ_BYP,
        EV_WRITE_THRU,
        EV_WRITE_EVICT,
        EV_WRITE_DIRTY,
        EV_REPLACE,
        EV_ATOMIC,
        EV_FILL,
        EV_WB_ACK,
        EV_PROBE,
        EV_BAD
    } line_event_e;

    localparam logic [1:0] RK_READ   = 2'd0;
    localparam logic [1:0] RK_WRITE  = 2'd1;
    localparam logic [1:0] RK_ATOMIC = 2'd2;
    localparam logic       RSPK_WBACK = 1'b1;

    localparam int OP_W   = 8;
    localparam int MEM_W  = 4;
    localparam int CORE_W = 2;

    localparam int OP_INV   = 0;
    localparam int OP_ALLOC = 1;
    localparam int OP_MERGE = 2;
    localparam int OP_FILL  = 3;
    localparam int OP_PACK  = 4;
    localparam int OP_UNBLK = 5;
    localparam int OP_PARK  = 6;
    localparam int OP_WAKE  = 7;

    localparam int MC_READ = 0;
    localparam int MC_WT   = 1;
    localparam int MC_WB   = 2;
    localparam int MC_ATOM = 3;

    localparam int CR_DATA = 0;
    localparam int CR_WACK = 1;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [MEM_W-1:0]  mem;
        logic [CORE_W-1:0] core;
        logic              err;
    } line_act_t;

endpackage

// File: rtl/l2ls_decode.sv
module l2ls_decode
    import l2ls_pkg::*;
(
    input  logic        wb_mode_i,
    input  logic        req_valid_i,
    input  logic [1:0]  req_kind_i,
    input  logic        req_slc_i,
    input  logic        req_avail_i,
    input  logic        rsp_valid_i,
    input  logic        rsp_kind_i,
    input  logic        prb_valid_i,
    output line_event_e ev_o,
    output logic        req_take_o,
    output logic        rsp_take_o,
    output logic        prb_take_o
);

    always_comb begin
        ev_o       = EV_NONE;
        req_take_o = 1'b0;
        rsp_take_o = 1'b0;
        prb_take_o = 1'b0;
        if (rsp_valid_i) begin
            rsp_take_o = 1'b1;
            ev_o       = (rsp_kind_i == RSPK_WBACK) ? EV_WB_ACK : EV_FILL;
        end else if (prb_valid_i) begin
            prb_take_o = 1'b1;
            ev_o       = EV_PROBE;
        end else if (req_valid_i) begin
            req_take_o = 1'b1;
            case (req_kind_i)
                RK_READ:   ev_o = req_slc_i ? EV_READ_BYP : EV_READ;
                RK_WRITE: begin
                    if (req_slc_i)
                        ev_o = req_avail_i ? EV_WRITE_EVICT : EV_WRITE_THRU;
                    else if (wb_mode_i)
                        ev_o = req_avail_i ? EV_WRITE_DIRTY : EV_REPLACE;
                    else
                        ev_o = EV_WRITE_THRU;
                end
                RK_ATOMIC: ev_o = EV_ATOMIC;
                default:   ev_o = EV_BAD;
            endcase
        end
    end

endmodule

// File: rtl/l2ls_next.sv
module l2ls_next
    import l2ls_pkg::*;
(
    input  line_state_e state_i,
    input  logic        pend_i,
    input  line_event_e ev_i,
    output line_state_e state_o,
    output logic        pend_o,
    output line_act_t   act_o
);

    logic busy;
    logic dirty;
    logic undef;

    always_comb begin
        state_o = state_i;
        pend_o  = pend_i;
        act_o   = '0;
        undef   = 1'b0;
        busy    = (state_i == LS_IV) || (state_i == LS_WI) || (state_i == LS_A);
        dirty   = (state_i == LS_M) || (state_i == LS_W);

        case (ev_i)
            EV_READ: begin
                case (state_i)
                    LS_I: begin
                        act_o.mem[MC_READ] = 1'b1;
                        state_o = LS_IV;
                    end
                    LS_IV: act_o.mem[MC_READ] = 1'b1;
                    LS_V, LS_M: act_o.core[CR_DATA] = 1'b1;
                    LS_W: begin
                        act_o.mem[MC_WB]   = 1'b1;
                        act_o.op[OP_PARK]  = 1'b1;
                        state_o = LS_WI;
                    end
                    default: act_o.op[OP_PARK] = 1'b1;
                endcase
            end

            EV_READ_BYP: begin
                if (busy) begin
                    act_o.op[OP_PARK] = 1'b1;
                end else begin
                    act_o.mem[MC_READ] = 1'b1;
                    act_o.mem[MC_WB]   = dirty;
                    act_o.op[OP_INV]   = (state_i != LS_I);
                    pend_o  = 1'b1;
                    state_o = LS_I;
                end
            end

            EV_WRITE_THRU: begin
                if (busy) begin
                    act_o.op[OP_PARK] = 1'b1;
                end else if (dirty) begin
                    undef = 1'b1;
                end else begin
                    act_o.mem[MC_WT]   = 1'b1;
                    act_o.op[OP_MERGE] = (state_i == LS_V);
                end
            end

            EV_WRITE_EVICT: begin
                case (state_i)
                    LS_I: act_o.mem[MC_WT] = 1'b1;
                    LS_V: begin
                        act_o.mem[MC_WT] = 1'b1;
                        act_o.op[OP_INV] = 1'b1;
                        state_o = LS_I;
                    end
                    LS_M, LS_W: begin
                        act_o.op[OP_MERGE] = 1'b1;
                        act_o.mem[MC_WB]   = 1'b1;
                        act_o.op[OP_INV]   = 1'b1;
                        state_o = LS_I;
                    end
                    default: act_o.op[OP_PARK] = 1'b1;
                endcase
            end

            EV_WRITE_DIRTY: begin
                if (busy) begin
                    act_o.op[OP_PARK] = 1'b1;
                end else begin
                    act_o.op[OP_MERGE]   = 1'b1;
                    act_o.core[CR_WACK]  = 1'b1;
                    case (state_i)
                        LS_I: begin
                            act_o.op[OP_ALLOC] = 1'b1;
                            state_o = LS_W;
                        end
                        LS_V, LS_M: state_o = LS_M;
                        default: state_o = state_i;
                    endcase
                end
            end

            EV_REPLACE: begin
                act_o.op[OP_INV]  = 1'b1;
                act_o.op[OP_PARK] = 1'b1;
                if (dirty) begin
                    act_o.mem[MC_WB] = 1'b1;
                    state_o = LS_WI;
                end else if (!busy) begin
                    state_o = LS_I;
                end
            end

            EV_ATOMIC: begin
                if (busy) begin
                    act_o.op[OP_PARK] = 1'b1;
                end else if (dirty) begin
                    act_o.mem[MC_WB]  = 1'b1;
                    act_o.op[OP_PARK] = 1'b1;
                    state_o = LS_WI;
                end else begin
                    act_o.op[OP_INV]   = 1'b1;
                    act_o.mem[MC_ATOM] = 1'b1;
                    state_o = LS_A;
                end
            end

            EV_FILL: begin
                if (pend_i) begin
                    act_o.core[CR_DATA] = 1'b1;
                    act_o.op[OP_UNBLK]  = 1'b1;
                    act_o.op[OP_WAKE]   = 1'b1;
                    pend_o = 1'b0;
                end else begin
                    case (state_i)
                        LS_IV: begin
                            act_o.op[OP_ALLOC]  = 1'b1;
                            act_o.op[OP_FILL]   = 1'b1;
                            act_o.core[CR_DATA] = 1'b1;
                            act_o.op[OP_UNBLK]  = 1'b1;
                            act_o.op[OP_WAKE]   = 1'b1;
                            state_o = LS_V;
                        end
                        LS_A: begin
                            act_o.core[CR_DATA] = 1'b1;
                            act_o.op[OP_WAKE]   = 1'b1;
                            state_o = LS_I;
                        end
                        default: undef = 1'b1;
                    endcase
                end
            end

            EV_WB_ACK: begin
                if (state_i == LS_WI) begin
                    act_o.op[OP_WAKE] = 1'b1;
                    state_o = LS_I;
                end else if (dirty) begin
                    undef = 1'b1;
                end else begin
                    act_o.core[CR_WACK] = 1'b1;
                end
            end

            EV_PROBE: begin
                act_o.op[OP_PACK] = 1'b1;
                case (state_i)
                    LS_V: begin
                        act_o.op[OP_INV] = 1'b1;
                        state_o = LS_I;
                    end
                    LS_M: state_o = LS_W;
                    default: state_o = state_i;
                endcase
            end

            EV_BAD: undef = 1'b1;

            default: state_o = state_i;
        endcase

        if (undef) begin
            state_o   = state_i;
            pend_o    = pend_i;
            act_o     = '0;
            act_o.err = 1'b1;
        end
    end

endmodule

// File: rtl/l2ls_delay.sv
module l2ls_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_pipe
            logic [W-1:0] stage_q [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign q_o = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/l2_line_ctrl.sv
module l2_line_ctrl
    import l2ls_pkg::*;
#(
    parameter int REQ_LAT = 50,
    parameter int RSP_LAT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic              req_slc_i,
    input  logic              req_avail_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_kind_i,
    input  logic              prb_valid_i,
    output logic              req_take_o,
    output logic              rsp_take_o,
    output logic              prb_take_o,
    output logic [2:0]        state_o,
    output logic [OP_W-1:0]   line_op_o,
    output logic [MEM_W-1:0]  mem_cmd_o,
    output logic [CORE_W-1:0] core_rsp_o,
    output logic              err_o
);

    typedef struct packed {
        line_state_e     state;
        logic            pend;
        logic [OP_W-1:0] op;
        logic            err;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    line_event_e ev;
    line_state_e state_nx;
    logic        pend_nx;
    line_act_t   act;

    l2ls_decode u_decode (
        .wb_mode_i   (wb_mode_i),
        .req_valid_i (req_valid_i),
        .req_kind_i  (req_kind_i),
        .req_slc_i   (req_slc_i),
        .req_avail_i (req_avail_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_kind_i  (rsp_kind_i),
        .prb_valid_i (prb_valid_i),
        .ev_o        (ev),
        .req_take_o  (req_take_o),
        .rsp_take_o  (rsp_take_o),
        .prb_take_o  (prb_take_o)
    );

    l2ls_next u_next (
        .state_i (ctl_q.state),
        .pend_i  (ctl_q.pend),
        .ev_i    (ev),
        .state_o (state_nx),
        .pend_o  (pend_nx),
        .act_o   (act)
    );

    always_comb begin
        ctl_d.state = state_nx;
        ctl_d.pend  = pend_nx;
        ctl_d.op    = act.op;
        ctl_d.err   = act.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    l2ls_delay #(.W(MEM_W), .DEPTH(REQ_LAT)) u_mem_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (act.mem),
        .q_o   (mem_cmd_o)
    );

    l2ls_delay #(.W(CORE_W), .DEPTH(RSP_LAT)) u_core_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (act.core),
        .q_o   (core_rsp_o)
    );

    assign state_o   = ctl_q.state;
    assign line_op_o = ctl_q.op;
    assign err_o     = ctl_q.err;

endmodule

// File: rtl/l2ls_checker.sv
module l2ls_checker
    import l2ls_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            rsp_valid_i,
    input logic            rsp_kind_i,
    input logic            prb_valid_i,
    input logic            req_take_o,
    input logic            rsp_take_o,
    input logic            prb_take_o,
    input logic [2:0]      state_o,
    input logic [OP_W-1:0] line_op_o,
    input logic            err_o
);

    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd6);

    a_r2_one_take: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_take_o, rsp_take_o, prb_take_o}));

    a_r2_rsp_first: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> rsp_take_o);

    a_r2_prb_second: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid_i && !rsp_valid_i) |-> prb_take_o);

    a_r10_probe_ack: assert property (@(posedge clk) disable iff (!rst_n)
        prb_take_o |=> line_op_o[OP_PACK]);

    a_r10_dirty_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_take_o && state_o == LS_M) |=> (state_o == LS_W));

    a_r11_wback_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take_o && rsp_kind_i == RSPK_WBACK && state_o == LS_WI)
        |=> (state_o == LS_I && line_op_o[OP_WAKE]));

    a_r14_err_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(state_o));

    a_r14_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (line_op_o == '0));

endmodule

bind l2_line_ctrl l2ls_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid_i (rsp_valid_i),
    .rsp_kind_i  (rsp_kind_i),
    .prb_valid_i (prb_valid_i),
    .req_take_o  (req_take_o),
    .rsp_take_o  (rsp_take_o),
    .prb_take_o  (prb_take_o),
    .state_o     (state_o),
    .line_op_o   (line_op_o),
    .err_o       (err_o)
);

// File: tb/tb_l2_line_ctrl.sv
module tb_l2_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int REQ_LAT    = 50;
    localparam int RSP_LAT    = 20;
    localparam int WIN        = REQ_LAT + 2;

    // stimulus codes
    localparam int S_RD = 0, S_RDB = 1, S_WEV = 2, S_WTB = 3, S_WRP = 4, S_WRA = 5;
    localparam int S_AT = 6, S_DATA = 7, S_WBK = 8, S_PRB = 9, S_BAD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wb_mode = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_slc = 1'b0;
    logic       req_avail = 1'b0;
    logic       rsp_valid = 1'b0;
    logic       rsp_kind = 1'b0;
    logic       prb_valid = 1'b0;
    logic       req_take, rsp_take, prb_take;
    logic [2:0] state;
    logic [7:0] line_op;
    logic [3:0] mem_cmd;
    logic [1:0] core_rsp;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_s;
    bit m_pd;

    // observations
    logic [2:0] o_st;
    logic [7:0] o_op;
    logic [3:0] o_mem, o_mem_stray;
    logic [1:0] o_core, o_core_stray;
    logic       o_err;
    logic [2:0] o_take;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2_line_ctrl #(.REQ_LAT(REQ_LAT), .RSP_LAT(RSP_LAT)) dut (
        .clk (clk), .rst_n (rst_n), .wb_mode_i (wb_mode),
        .req_valid_i (req_valid), .req_kind_i (req_kind), .req_slc_i (req_slc),
        .req_avail_i (req_avail), .rsp_valid_i (rsp_valid), .rsp_kind_i (rsp_kind),
        .prb_valid_i (prb_valid), .req_take_o (req_take), .rsp_take_o (rsp_take),
        .prb_take_o (prb_take), .state_o (state), .line_op_o (line_op),
        .mem_cmd_o (mem_cmd), .core_rsp_o (core_rsp), .err_o (err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected behaviour, written from the requirements
    function automatic void model(input int s, input bit pd, input int stim, input bit wb,
                                  output int ns, output bit npd, output logic [7:0] op,
                                  output logic [3:0] mem, output logic [1:0] core,
                                  output bit er);
        bit busy;
        bit drt;
        int ev;
        busy = (s >= 4);
        drt  = (s == 2) || (s == 3);
        ns = s; npd = pd; op = '0; mem = '0; core = '0; er = 0;
        case (stim)
            S_RD:  ev = 0;
            S_RDB: ev = 1;
            S_WEV: ev = 3;
            S_WTB: ev = 2;
            S_WRP: ev = wb ? 4 : 2;
            S_WRA: ev = wb ? 5 : 2;
            S_AT:  ev = 6;
            S_DATA: ev = 7;
            S_WBK: ev = 8;
            S_PRB: ev = 9;
            default: ev = 10;
        endcase
        case (ev)
            0: begin
                if (s == 0) begin mem[0] = 1; ns = 4; end
                else if (s == 4) mem[0] = 1;
                else if (s == 1 || s == 2) core[0] = 1;
                else if (s == 3) begin mem[2] = 1; op[6] = 1; ns = 5; end
                else op[6] = 1;
            end
            1: begin
                if (busy) op[6] = 1;
                else begin
                    if (drt) mem[2] = 1;
                    if (s != 0) op[0] = 1;
                    mem[0] = 1; npd = 1; ns = 0;
                end
            end
            2: begin
                if (busy) op[6] = 1;
                else if (drt) er = 1;
                else begin mem[1] = 1; if (s == 1) op[2] = 1; end
            end
            3: begin
                if (busy) op[6] = 1;
                else if (s == 0) mem[1] = 1;
                else if (s == 1) begin mem[1] = 1; op[0] = 1; ns = 0; end
                else begin op[2] = 1; mem[2] = 1; op[0] = 1; ns = 0; end
            end
            4: begin
                if (busy) op[6] = 1;
                else begin
                    op[2] = 1; core[1] = 1;
                    if (s == 0) begin op[1] = 1; ns = 3; end
                    else if (s != 3) ns = 2;
                end
            end
            5: begin
                op[0] = 1; op[6] = 1;
                if (drt) begin mem[2] = 1; ns = 5; end
                else if (!busy) ns = 0;
            end
            6: begin
                if (busy) op[6] = 1;
                else if (drt) begin mem[2] = 1; op[6] = 1; ns = 5; end
                else begin op[0] = 1; mem[3] = 1; ns = 6; end
            end
            7: begin
                if (pd) begin core[0] = 1; op[5] = 1; op[7] = 1; npd = 0; end
                else if (s == 4) begin
                    op[1] = 1; op[3] = 1; core[0] = 1; op[5] = 1; op[7] = 1; ns = 1;
                end else if (s == 6) begin core[0] = 1; op[7] = 1; ns = 0; end
                else er = 1;
            end
            8: begin
                if (s == 5) begin op[7] = 1; ns = 0; end
                else if (drt) er = 1;
                else core[1] = 1;
            end
            9: begin
                op[4] = 1;
                if (s == 1) begin op[0] = 1; ns = 0; end
                else if (s == 2) ns = 3;
            end
            default: er = 1;
        endcase
        if (er) begin ns = s; npd = pd; op = '0; mem = '0; core = '0; end
    endfunction

    function automatic string tag_of(input int stim, input bit pd);
        case (stim)
            S_RD:   return "R4";
            S_RDB:  return "R5";
            S_WEV, S_WTB: return "R3 R6";
            S_WRP:  return "R3 R7";
            S_WRA:  return "R3 R9";
            S_AT:   return "R8";
            S_DATA: return pd ? "R12" : "R11";
            S_WBK:  return "R11";
            S_PRB:  return "R10";
            default: return "R14";
        endcase
    endfunction

    // present up to one request, one response and one probe (-1 = none)
    task automatic apply3(input int rq, input int rs, input int pb);
        @(negedge clk);
        if (rq >= 0) begin
            req_valid = 1'b1;
            case (rq)
                S_RD:  begin req_kind = 2'd0; req_slc = 0; end
                S_RDB: begin req_kind = 2'd0; req_slc = 1; end
                S_WEV: begin req_kind = 2'd1; req_slc = 1; req_avail = 1; end
                S_WTB: begin req_kind = 2'd1; req_slc = 1; req_avail = 0; end
                S_WRP: begin req_kind = 2'd1; req_slc = 0; req_avail = 1; end
                S_WRA: begin req_kind = 2'd1; req_slc = 0; req_avail = 0; end
                S_AT:  begin req_kind = 2'd2; req_slc = 0; end
                default: begin req_kind = 2'd3; req_slc = 0; end
            endcase
        end
        if (rs >= 0) begin rsp_valid = 1'b1; rsp_kind = (rs == S_WBK); end
        if (pb >= 0) prb_valid = 1'b1;
        #1;
        o_take = {req_take, rsp_take, prb_take};
        @(negedge clk);
        req_valid = 0; rsp_valid = 0; prb_valid = 0;
        req_kind = 0; req_slc = 0; req_avail = 0; rsp_kind = 0;
        o_st = state; o_op = line_op; o_err = err;
        o_mem = '0; o_core = '0; o_mem_stray = '0; o_core_stray = '0;
        for (int k = 1; k <= WIN; k++) begin
            if (k > 1) @(negedge clk);
            if (k == REQ_LAT) o_mem = mem_cmd; else o_mem_stray |= mem_cmd;
            if (k == RSP_LAT) o_core = core_rsp; else o_core_stray |= core_rsp;
        end
    endtask

    task automatic compare(input string tag, input int ns, input logic [7:0] op,
                           input logic [3:0] mem, input logic [1:0] core, input bit er);
        chk(o_st == ns[2:0], tag, "state", o_st, ns);
        chk(o_op == op, tag, "line_op", o_op, op);
        chk(o_err == er, {tag, " R14"}, "err", o_err, er);
        chk(o_mem == mem, {tag, " R13"}, "mem_cmd at latency", o_mem, mem);
        chk(o_core == core, {tag, " R13"}, "core_rsp at latency", o_core, core);
        chk(o_mem_stray == 0, "R13", "mem_cmd outside latency", o_mem_stray, 0);
        chk(o_core_stray == 0, "R13", "core_rsp outside latency", o_core_stray, 0);
    endtask

    task automatic step(input int stim);
        int ns; bit npd; logic [7:0] op; logic [3:0] mem; logic [1:0] core; bit er;
        model(m_s, m_pd, stim, wb_mode, ns, npd, op, mem, core, er);
        if (stim == S_DATA || stim == S_WBK) apply3(-1, stim, -1);
        else if (stim == S_PRB) apply3(-1, -1, 0);
        else apply3(stim, -1, -1);
        compare(tag_of(stim, m_pd), ns, op, mem, core, er);
        m_s = ns; m_pd = npd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_s = 0; m_pd = 0;
        @(negedge clk);
        chk(state == 3'd0, "R1", "reset state", state, 0);
    endtask

    task automatic goto_state(input int s);
        do_reset();
        case (s)
            1: begin step(S_RD); step(S_DATA); end
            2: begin step(S_RD); step(S_DATA); step(S_WRP); end
            3: step(S_WRP);
            4: step(S_RD);
            5: begin step(S_WRP); step(S_RD); end
            6: step(S_AT);
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet outputs after reset
        do_reset();
        chk(line_op == 0 && mem_cmd == 0 && core_rsp == 0 && err == 0, "R1",
            "outputs after reset", {line_op, mem_cmd, core_rsp, err}, 0);

        // full sweep in write-back mode
        wb_mode = 1;
        for (int s = 0; s < 7; s++) begin
            for (int t = 0; t <= S_BAD; t++) begin
                goto_state(s);
                step(t);
            end
        end

        // R12: outstanding bypass read, then its data
        goto_state(0); step(S_RDB); step(S_DATA);
        goto_state(1); step(S_RDB); step(S_DATA);
        goto_state(3); step(S_RDB); step(S_DATA);

        // R3: write-through mode never makes dirty lines
        wb_mode = 0;
        goto_state(0); step(S_WRP); step(S_WRA);
        goto_state(1); step(S_WRP); step(S_WRA);
        goto_state(4); step(S_WRP);
        wb_mode = 1;

        // R2: response beats probe and request
        begin
            int ns; bit npd; logic [7:0] op; logic [3:0] mem; logic [1:0] core; bit er;
            goto_state(4);
            model(m_s, m_pd, S_DATA, wb_mode, ns, npd, op, mem, core, er);
            apply3(S_RD, S_DATA, 0);
            chk(o_take == 3'b010, "R2", "takes rsp+prb+req", o_take, 3'b010);
            compare("R2", ns, op, mem, core, er);
            m_s = ns; m_pd = npd;
            // probe beats request
            model(m_s, m_pd, S_PRB, wb_mode, ns, npd, op, mem, core, er);
            apply3(S_RD, -1, 0);
            chk(o_take == 3'b001, "R2", "takes prb+req", o_take, 3'b001);
            compare("R2", ns, op, mem, core, er);
            m_s = ns; m_pd = npd;
            // request alone
            apply3(S_RD, -1, -1);
            chk(o_take == 3'b100, "R2", "takes req", o_take, 3'b100);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule